// File: doc/BRIEF.md
# Bus-Mapped SPI Master Controller

This block is an SPI master for an 8-bit microprocessor bus. It is timed by a system clock `clk`. The host reaches it through four byte locations, chosen by two address bits. An access is qualified by an active-high select, an active-low select and the high phase of the bus clock `phi2`. Writing a byte to the data location starts an automatic eight-bit exchange on MOSI, MISO and SCLK. The byte gathered from MISO is then read from the same location.

A control byte sets the SPI mode (clock polarity and clock phase). It also selects where the shift timing comes from and enables the interrupt. One shift-clock half-period passes for each rising edge of the chosen source. The source is either `phi2` or the external input `ext_clk`. Both are sampled in the `clk` domain.

A status byte reports busy and transfer-complete. The completion can drive an active-low interrupt or be polled. A byte-wide select register, visible at two locations, drives eight slave-select outputs directly.

Top module: `spi_bus_master`

## Requirements
- R1: While `arst_n` is low, and after it is released, the outputs are: `ss_n` = 8'hFF, `sclk` = 0, `mosi` = 0, `irq_n` = 1, `dout_oe` = 0. The control and status bytes read as zero.
- R2: An access happens only when `cs1`=1, `cs2_n`=0 and `phi2`=1.
  - Otherwise `dout_oe`=0, `dout`=0, and writes change nothing.
  - A held access acts once, in its first qualified cycle.
- R3: Addresses 2'b10 and 2'b11 both read and write one select byte. That byte appears unchanged on `ss_n` one cycle after the write.
- R4: A write to address 2'b00 shifts the byte out on `mosi` MSB first, eight bits per transfer. A read of 2'b00 returns the eight bits sampled from `miso`, the first sampled bit ending up in bit 7.
- R5: While idle, `sclk` equals control bit 1 (CPOL). During a transfer, each selected source rising edge toggles `sclk`, so a transfer spans 16 edges.
- R6: Control bit 0 (CPHA) sets the sampling edge.
  - When CPHA=0, `miso` is sampled on odd-numbered `sclk` edges and `mosi` changes on even-numbered ones.
  - When CPHA=1, the roles swap.
  - Edges are counted from 1.
- R7: Control bit 2 selects the shift source: 0 uses rising edges of `phi2`, 1 uses rising edges of `ext_clk`. With the external source and no `ext_clk` edges, a transfer stays busy.
- R8: Reading address 2'b01 returns status with bit 7 = complete and bit 6 = busy, the other bits zero.
  - Busy is set by the starting write.
  - Complete is set when the 16th edge ends the transfer.
  - Complete is cleared by a read of the data location or by a new start.
- R9: With control bit 7 (interrupt enable) set, `irq_n` is low exactly while complete is set. A data read releases it.
- R10: A data write while busy is ignored: the running transfer and its received byte are unaffected. Control bits 6:3 are reserved and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| cs1 | input | 1 | Active-high chip select |
| cs2_n | input | 1 | Active-low chip select |
| phi2 | input | 1 | Bus clock phase, access qualifier and optional shift source |
| rw_n | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Register location |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host, zero when not driven |
| dout_oe | output | 1 | Read data output enable |
| ext_clk | input | 1 | External shift source |
| miso | input | 1 | Serial data from slave |
| mosi | output | 1 | Serial data to slave |
| sclk | output | 1 | Serial shift clock |
| ss_n | output | 8 | Slave select outputs |
| irq_n | output | 1 | Active-low interrupt |

## Verification
- **Reads:** read data is combinational in the first `phi2`-high cycle of an access, so the bench samples `dout` shortly after that falling edge. It checks there the values held since the previous rising edge.
- **Register writes:** control and select writes take effect at the rising edge that ends the first qualified cycle, so `ss_n` and `sclk` idle levels are due one edge later.
- **Transfers:** a transfer's `sclk` and `mosi` changes follow each selected source rise by exactly one rising edge of `clk`. Complete and `irq_n` come due at the edge that processes the 16th source rise.
- **Reference model:** the model advances on every rising edge in that same order, and the registered outputs are compared on every falling edge. Readback checks use model values frozen since the last rising edge.

// File: rtl/spi_bus_pkg.sv
package spi_bus_pkg;

  typedef enum logic [1:0] {
    LOC_DATA = 2'b00,
    LOC_CSR  = 2'b01,
    LOC_SELA = 2'b10,
    LOC_SELB = 2'b11
  } bus_loc_e;

  // used control bits only; reserved bits 6:3 are not stored
  typedef struct packed {
    logic irq_en;   // byte bit 7
    logic ext_src;  // byte bit 2
    logic cpol;     // byte bit 1
    logic cpha;     // byte bit 0
  } ctl_t;

endpackage

// File: rtl/spi_bus_rst_sync.sv
module spi_bus_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/spi_bus_regs.sv
module spi_bus_regs
  import spi_bus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs1,
  input  logic          cs2_n,
  input  logic          phi2,
  input  logic          rw_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] din,
  input  logic          busy,
  input  logic          done,
  input  logic [DW-1:0] rx,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output ctl_t          ctl,
  output logic [DW-1:0] ss_n,
  output logic          start,
  output logic          done_clr,
  output logic          ss_wr
);
  localparam int STAT_PAD = DW - 2;

  logic     acc, acc_q, stb, wr, rd;
  bus_loc_e loc;
  ctl_t     ctl_d, ctl_q;
  logic [DW-1:0] ss_d, ss_q;
  logic     ctl_wr;

  assign loc = bus_loc_e'(addr);
  assign acc = cs1 & ~cs2_n & phi2;
  assign stb = acc & ~acc_q;
  assign wr  = stb & ~rw_n;
  assign rd  = stb & rw_n;

  assign ctl_wr   = wr & (loc == LOC_CSR);
  assign ss_wr    = wr & ((loc == LOC_SELA) | (loc == LOC_SELB));
  assign start    = wr & (loc == LOC_DATA) & ~busy;
  assign done_clr = start | (rd & (loc == LOC_DATA));

  always_comb begin
    ctl_d = ctl_q;
    ss_d  = ss_q;
    if (ctl_wr) ctl_d = '{irq_en: din[7], ext_src: din[2], cpol: din[1], cpha: din[0]};
    if (ss_wr)  ss_d  = din;
  end

  always_comb begin
    dout_oe = acc & rw_n;
    dout    = '0;
    if (dout_oe) begin
      unique case (loc)
        LOC_DATA: dout = rx;
        LOC_CSR:  dout = {done, busy, {STAT_PAD{1'b0}}};
        default:  dout = ss_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      ctl_q <= '0;
      ss_q  <= '1;
    end else begin
      acc_q <= acc;
      if (ctl_wr) ctl_q <= ctl_d;
      if (ss_wr)  ss_q  <= ss_d;
    end
  end

  assign ctl  = ctl_q;
  assign ss_n = ss_q;
endmodule

// File: rtl/spi_bus_shifter.sv
module spi_bus_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] tx,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          miso,
  input  logic          done_clr,
  output logic          sclk,
  output logic          mosi,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx
);
  localparam int HW = $clog2(2 * DW);
  localparam logic [HW-1:0] LAST = HW'(2 * DW - 1);

  logic          busy_d, busy_q, done_d, done_q, lvl_d, lvl_q;
  logic [HW-1:0] hc_d, hc_q;
  logic [DW-1:0] sh_d, sh_q, rx_d, rx_q;
  logic          step, lead, fin, upd;

  assign step = busy_q & tick;
  assign lead = ~hc_q[0];
  assign fin  = step & (hc_q == LAST);
  assign upd  = start | step;

  always_comb begin
    busy_d = busy_q;
    lvl_d  = lvl_q;
    hc_d   = hc_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    if (start) begin
      busy_d = 1'b1;
      lvl_d  = 1'b0;
      hc_d   = '0;
      sh_d   = tx;
    end else if (step) begin
      lvl_d = ~lvl_q;
      hc_d  = hc_q + 1'b1;
      if (lead != cpha)
        rx_d = {rx_q[DW-2:0], miso};
      else if (hc_q != '0 && hc_q != LAST)
        sh_d = {sh_q[DW-2:0], 1'b0};
      if (fin) busy_d = 1'b0;
    end
  end

  always_comb begin
    done_d = done_q;
    if (done_clr) done_d = 1'b0;
    if (fin)      done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lvl_q  <= 1'b0;
      hc_q   <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      if (upd) begin
        busy_q <= busy_d;
        lvl_q  <= lvl_d;
        hc_q   <= hc_d;
        sh_q   <= sh_d;
        rx_q   <= rx_d;
      end
      if (done_clr | fin) done_q <= done_d;
    end
  end

  assign sclk = cpol ^ lvl_q;
  assign mosi = sh_q[DW-1];
  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rx_q;
endmodule

// File: rtl/spi_bus_master.sv
module spi_bus_master
  import spi_bus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          cs1,
  input  logic          cs2_n,
  input  logic          phi2,
  input  logic          rw_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  input  logic          ext_clk,
  input  logic          miso,
  output logic          mosi,
  output logic          sclk,
  output logic [DW-1:0] ss_n,
  output logic          irq_n
);
  logic          rst_s;
  ctl_t          ctl;
  logic          busy, done, start, done_clr, ss_wr, tick;
  logic          phi2_q, ext_q;
  logic [DW-1:0] rx;

  spi_bus_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n_o(rst_s)
  );

  spi_bus_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_s),
    .cs1     (cs1),
    .cs2_n   (cs2_n),
    .phi2    (phi2),
    .rw_n    (rw_n),
    .addr    (addr),
    .din     (din),
    .busy    (busy),
    .done    (done),
    .rx      (rx),
    .dout    (dout),
    .dout_oe (dout_oe),
    .ctl     (ctl),
    .ss_n    (ss_n),
    .start   (start),
    .done_clr(done_clr),
    .ss_wr   (ss_wr)
  );

  // edge detect of the selected shift source
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      phi2_q <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      phi2_q <= phi2;
      ext_q  <= ext_clk;
    end
  end

  assign tick = ctl.ext_src ? (ext_clk & ~ext_q) : (phi2 & ~phi2_q);

  spi_bus_shifter #(.DW(DW)) u_shift (
    .clk     (clk),
    .rst_n   (rst_s),
    .tick    (tick),
    .start   (start),
    .tx      (din),
    .cpol    (ctl.cpol),
    .cpha    (ctl.cpha),
    .miso    (miso),
    .done_clr(done_clr),
    .sclk    (sclk),
    .mosi    (mosi),
    .busy    (busy),
    .done    (done),
    .rx      (rx)
  );

  assign irq_n = ~(done & ctl.irq_en);
endmodule

// File: rtl/spi_bus_master_chk.sv
module spi_bus_master_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          sclk,
  input logic          cpol,
  input logic          cpha,
  input logic          mosi,
  input logic          irq_n,
  input logic          dout_oe,
  input logic          cs1,
  input logic          cs2_n,
  input logic          phi2,
  input logic [DW-1:0] ss_n,
  input logic          ss_wr
);
  // R2
  oe_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (cs1 && !cs2_n && phi2));

  // R3
  ss_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ss_n) |-> $past(ss_wr));

  // R5
  sclk_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol));

  // R6
  mosi_change_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(cpha) && $stable(cpol) && !$stable(mosi))
      |-> (sclk == (cpol ^ cpha)));

  // R8
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));

  // R9
  irq_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (done && !busy));
endmodule

bind spi_bus_master spi_bus_master_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_s),
  .busy   (busy),
  .done   (done),
  .sclk   (sclk),
  .cpol   (ctl.cpol),
  .cpha   (ctl.cpha),
  .mosi   (mosi),
  .irq_n  (irq_n),
  .dout_oe(dout_oe),
  .cs1    (cs1),
  .cs2_n  (cs2_n),
  .phi2   (phi2),
  .ss_n   (ss_n),
  .ss_wr  (ss_wr)
);

// File: tb/spi_bus_master_tb.sv
module spi_bus_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 150000;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       cs1 = 1'b0, cs2_n = 1'b1, phi2 = 1'b0, rw_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, ss_n;
  logic       dout_oe, ext_clk = 1'b0, miso, mosi, sclk, irq_n;
  logic       loop_en = 1'b1, miso_fix = 1'b0, ext_run = 1'b0;
  int         checks = 0, errors = 0;
  bit         cmp_on = 1'b0, ended = 1'b0;

  assign miso = loop_en ? mosi : miso_fix;

  spi_bus_master u_dut (
    .clk(clk), .arst_n(arst_n), .cs1(cs1), .cs2_n(cs2_n), .phi2(phi2),
    .rw_n(rw_n), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .ext_clk(ext_clk), .miso(miso), .mosi(mosi), .sclk(sclk),
    .ss_n(ss_n), .irq_n(irq_n)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // bus clock: two cycles low, two high; external source: period six
  int pc = 0, ec = 0;
  always @(negedge clk) begin
    pc = (pc + 1) % 4;
    phi2 = (pc >= 2);
    if (ext_run) begin
      ec = (ec + 1) % 6;
      ext_clk = (ec >= 3);
    end else begin
      ext_clk = 1'b0;
    end
  end

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_sh, m_rx, m_ctrl, m_ss;
  bit m_busy, m_done, m_lvl, m_accq, m_phq, m_exq;
  int m_h, rcnt;

  task automatic m_reset();
    m_sh = 0; m_rx = 0; m_ctrl = 0; m_ss = 8'hFF;
    m_busy = 0; m_done = 0; m_lvl = 0; m_h = 0;
    m_accq = 0; m_phq = 0; m_exq = 0;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!arst_n) begin
      rcnt = 0; m_reset();
    end else if (rcnt < 2) begin
      rcnt++; m_reset();
    end else begin
      bit acc, stb, rise, ob, fin, st;
      acc  = cs1 && !cs2_n && phi2;
      stb  = acc && !m_accq;
      rise = m_ctrl[2] ? (ext_clk && !m_exq) : (phi2 && !m_phq);
      ob   = m_busy;
      fin  = 0;
      if (ob && rise) begin
        bit lead;
        lead = (m_h % 2) == 0;
        if (lead != m_ctrl[0]) m_rx = {m_rx[6:0], miso};
        else if (m_h != 0 && m_h != 15) m_sh = m_sh << 1;
        m_lvl = !m_lvl;
        if (m_h == 15) begin m_busy = 0; fin = 1; end
        m_h++;
      end
      st = stb && !rw_n && addr == 2'b00 && !ob;
      if (stb && rw_n && addr == 2'b00) m_done = 0;
      if (st) begin
        m_busy = 1; m_sh = din; m_h = 0; m_lvl = 0; m_done = 0;
      end
      if (fin) m_done = 1;
      if (stb && !rw_n && addr == 2'b01) m_ctrl = din;
      if (stb && !rw_n && addr[1]) m_ss = din;
      m_accq = acc; m_phq = phi2; m_exq = ext_clk;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // registered outputs compared against the model every cycle
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(sclk == (m_ctrl[1] ^ m_lvl), "R5 sclk", sclk, m_ctrl[1] ^ m_lvl);
      chk(mosi == m_sh[7], "R4 mosi", mosi, m_sh[7]);
      chk(ss_n == m_ss, "R3 ss_n", ss_n, m_ss);
      chk(irq_n == !(m_done && m_ctrl[7]), "R9 irq_n", irq_n, !(m_done && m_ctrl[7]));
    end
  end

  // ---------------- bus access ----------------
  task automatic bus(input bit c1, input bit c2n, input bit rd, input logic [1:0] a,
                     input logic [7:0] d, output logic [7:0] q);
    @(negedge clk); #1;
    while (phi2) begin @(negedge clk); #1; end
    cs1 = c1; cs2_n = c2n; rw_n = rd; addr = a; din = d;
    chk(!dout_oe, "R2 oe while phi2 low", dout_oe, 0);
    do begin @(negedge clk); #1; end while (!phi2);
    q = dout;
    while (phi2) begin @(negedge clk); #1; end
    cs1 = 1'b0; cs2_n = 1'b1; rw_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] q;
    bus(1, 0, 0, a, d, q);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] q);
    bus(1, 0, 1, a, 8'h00, q);
  endtask

  task automatic wait_done(input string req);
    logic [7:0] q = 8'h00;
    for (int i = 0; i < 100; i++) begin
      rd(2'b01, q);
      if (q[7]) break;
    end
    chk(q[7] && !q[6], req, q, 8'h80);
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] tx, input logic [7:0] exp, input string req);
    logic [7:0] q;
    wr(2'b01, c);
    @(negedge clk); #1;
    chk(sclk == c[1], "R5 idle level", sclk, c[1]);
    wr(2'b00, tx);
    rd(2'b01, q);
    chk(q == 8'h40, "R8 busy after start", q, 8'h40);
    wait_done("R8 complete flag");
    rd(2'b00, q);
    chk(q == exp, req, q, exp);
    rd(2'b01, q);
    chk(q == 8'h00, "R8 complete cleared by data read", q, 8'h00);
  endtask

  task automatic finish_sim();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_sim();
  end

  initial begin
    logic [7:0] q;
    repeat (4) @(negedge clk);
    #1;
    // R1 while reset held
    chk(ss_n == 8'hFF, "R1 ss_n in reset", ss_n, 8'hFF);
    chk(sclk == 0 && mosi == 0, "R1 sclk/mosi in reset", {sclk, mosi}, 0);
    chk(irq_n == 1 && dout_oe == 0, "R1 irq_n/oe in reset", {irq_n, dout_oe}, 2'b10);
    @(negedge clk); arst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
    rd(2'b01, q);
    chk(q == 8'h00, "R1 status after reset", q, 8'h00);

    // R3 select byte, both locations
    wr(2'b10, 8'hA5);
    rd(2'b11, q);
    chk(q == 8'hA5, "R3 read alias", q, 8'hA5);
    chk(ss_n == 8'hA5, "R3 ss_n pins", ss_n, 8'hA5);
    wr(2'b11, 8'h3C);
    rd(2'b10, q);
    chk(q == 8'h3C, "R3 read other alias", q, 8'h3C);

    // R2 unqualified accesses
    bus(0, 0, 1, 2'b10, 8'h00, q);
    chk(q == 8'h00, "R2 read with cs1 low", q, 8'h00);
    bus(1, 1, 0, 2'b10, 8'h00, q);
    chk(ss_n == 8'h3C, "R2 write with cs2_n high ignored", ss_n, 8'h3C);
    bus(0, 1, 0, 2'b01, 8'h02, q);
    @(negedge clk); #1;
    chk(sclk == 1'b0, "R2 control write ignored", sclk, 0);

    // R4 R5 R6 all four modes, loopback, bus clock source
    for (int m = 0; m < 4; m++) begin
      logic [7:0] tx;
      tx = 8'hC5 + 8'(m * 8'h13);
      xfer(8'(m), tx, tx, "R6 loopback byte per mode");
    end

    // R10 reserved control bits have no effect (mode 1 plus bits 6:3)
    xfer(8'h79, 8'h6E, 8'h6E, "R10 reserved control bits");

    // R4 constant miso
    loop_en = 1'b0; miso_fix = 1'b1;
    xfer(8'h00, 8'h12, 8'hFF, "R4 received ones");
    miso_fix = 1'b0;
    xfer(8'h03, 8'hFF, 8'h00, "R4 received zeros");
    loop_en = 1'b1;

    // R7 external source: stalls without edges, runs with them
    wr(2'b01, 8'h04);
    wr(2'b00, 8'h9A);
    repeat (100) @(negedge clk);
    rd(2'b01, q);
    chk(q == 8'h40, "R7 stalled without ext_clk", q, 8'h40);
    ext_run = 1'b1;
    wait_done("R7 complete on ext_clk");
    rd(2'b00, q);
    chk(q == 8'h9A, "R7 byte via ext_clk", q, 8'h9A);
    ext_run = 1'b0;

    // R9 interrupt
    loop_en = 1'b0; miso_fix = 1'b1;
    wr(2'b01, 8'h80);
    wr(2'b00, 8'h55);
    chk(irq_n == 1'b1, "R9 irq_n high while busy", irq_n, 1);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #1;
      if (!irq_n) break;
    end
    chk(irq_n == 1'b0, "R9 irq_n asserted on completion", irq_n, 0);
    rd(2'b00, q);
    chk(q == 8'hFF, "R9 data read", q, 8'hFF);
    @(negedge clk); #1;
    chk(irq_n == 1'b1, "R9 irq_n released by data read", irq_n, 1);
    loop_en = 1'b1;

    // R10 write while busy ignored
    wr(2'b01, 8'h00);
    wr(2'b00, 8'h81);
    wr(2'b00, 8'h42);
    wait_done("R10 first transfer completes");
    rd(2'b00, q);
    chk(q == 8'h81, "R10 busy write ignored", q, 8'h81);

    repeat (4) @(negedge clk);
    finish_sim();
  end
endmodule